// File: doc/BRIEF.md
# Four-Bit Ripple-Carry ALU

This block is the arithmetic and logic unit of a small teaching processor. It takes a register operand A and a second operand Y. Y comes from one of two places: a register value or an immediate constant held in the instruction word. One immediate-select bit makes that choice. A two-bit operation code chooses the result: the arithmetic path, a bitwise AND, a bitwise OR, or the complement of A. A separate subtract control decides whether the arithmetic path adds or subtracts.

The block is purely combinational. Addition goes through a chain of full adders. Each stage passes its carry to the stage above. Subtraction uses the same chain. The Y operand is complemented on its way into the chain, and the lowest carry-in is forced to one, so the chain computes A + ~Y + 1. Operands are two's-complement values with the sign in the top bit. The carry-out gives the unsigned carry of the arithmetic path.

Top module: `rc_alu`

## Requirements
- R1: With op_i = 2'b00 and sub_i = 0, res_o equals (A + Y) mod 2^WIDTH and cout_o equals bit WIDTH of the unsigned sum A + Y.
- R2: With op_i = 2'b00 and sub_i = 1, res_o equals (A - Y) mod 2^WIDTH. cout_o is the carry of A + ~Y + 1, so it is 1 exactly when A >= Y as unsigned values.
- R3: With op_i = 2'b01, res_o equals A & Y and cout_o is 0.
- R4: With op_i = 2'b10, res_o equals A | Y and cout_o is 0.
- R5: With op_i = 2'b11, res_o equals ~A and cout_o is 0. Neither Y source has any effect on res_o or cout_o.
- R6: Y is reg_y_i when imm_sel_i = 0 and imm_i when imm_sel_i = 1. The source that is not selected has no effect on res_o or cout_o.
- R7: When op_i is not 2'b00, sub_i has no effect on res_o or cout_o.
- R8: Read as two's-complement values, the subtract result equals the signed difference A - Y whenever that difference lies within the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A (register) |
| reg_y_i | input | WIDTH | Register value for operand Y |
| imm_i | input | WIDTH | Immediate constant for operand Y |
| imm_sel_i | input | 1 | 1 selects imm_i as Y, 0 selects reg_y_i |
| op_i | input | 2 | Operation: 00 arithmetic, 01 AND, 10 OR, 11 NOT A |
| sub_i | input | 1 | Selects subtract on the arithmetic path |
| res_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry-out of the arithmetic path, 0 otherwise |

## Verification
The hardest case to reach from the ports is a carry that travels through every stage. In an add this needs A + Y to be exactly 2^WIDTH with every propagate bit set. In a subtract it needs Y = 0, so that the injected carry ripples out to the top. Checking each of these cases needs the right operand pair and the right Y source selected together. The stimulus therefore sweeps every operand pair under every operation and both Y sources, and the Y source that is not selected gets a random value each time. Directed pairs such as 15+1, 0-0 and 8-1 are then added, along with random sweeps that toggle sub_i under the logic operations.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;
  typedef enum logic [1:0] {
    OP_ARITH = 2'b00,
    OP_AND   = 2'b01,
    OP_OR    = 2'b10,
    OP_NOTA  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/rc_alu_fa.sv
module rc_alu_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  // majority of the three inputs
  assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/rc_alu_chain.sv
module rc_alu_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    rc_alu_fa u_fa (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (carry[g]),
      .s_o (sum_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/rc_alu_ysel.sv
module rc_alu_ysel #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] reg_y_i,
  input  logic [WIDTH-1:0] imm_i,
  input  logic             imm_sel_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] y_o,
  output logic [WIDTH-1:0] y_add_o
);
  assign y_o     = imm_sel_i ? imm_i : reg_y_i;
  assign y_add_o = y_o ^ {WIDTH{inv_i}};
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] reg_y_i,
  input  logic [WIDTH-1:0] imm_i,
  input  logic             imm_sel_i,
  input  logic [1:0]       op_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  alu_op_e         op;
  logic            do_sub;
  logic [WIDTH-1:0] y_val, y_add, sum;
  logic            chain_cout;

  assign op     = alu_op_e'(op_i);
  assign do_sub = sub_i & (op == OP_ARITH);

  rc_alu_ysel #(.WIDTH(WIDTH)) u_ysel (
    .reg_y_i   (reg_y_i),
    .imm_i     (imm_i),
    .imm_sel_i (imm_sel_i),
    .inv_i     (do_sub),
    .y_o       (y_val),
    .y_add_o   (y_add)
  );

  // subtract: same chain, inverted Y, carry-in forced high
  rc_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i    (a_i),
    .y_i    (y_add),
    .cin_i  (do_sub),
    .sum_o  (sum),
    .cout_o (chain_cout)
  );

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    unique case (op)
      OP_ARITH: begin
        res_o  = sum;
        cout_o = chain_cout;
      end
      OP_AND:  res_o = a_i & y_val;
      OP_OR:   res_o = a_i | y_val;
      OP_NOTA: res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rc_alu_chk.sv
module rc_alu_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] reg_y_i,
  input logic [WIDTH-1:0] imm_i,
  input logic             imm_sel_i,
  input logic [1:0]       op_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o
);
  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   wide_add, wide_sub;

  always_comb begin
    y        = imm_sel_i ? imm_i : reg_y_i;
    wide_add = {1'b0, a_i} + {1'b0, y};
    wide_sub = {1'b0, a_i} - {1'b0, y};

    if (op_i == 2'b00 && !sub_i)
      p_add_r1: assert ({cout_o, res_o} == wide_add);
    if (op_i == 2'b00 && sub_i)
      p_sub_r2: assert (res_o == wide_sub[WIDTH-1:0] && cout_o == (a_i >= y));
    if (op_i == 2'b01)
      p_and_r3: assert (res_o == (a_i & y));
    if (op_i == 2'b10)
      p_or_r4: assert (res_o == (a_i | y));
    if (op_i == 2'b11)
      p_not_r5: assert (res_o == ~a_i);
    if (op_i != 2'b00)
      p_logic_nocarry_r7: assert (!cout_o);
  end
endmodule

bind rc_alu rc_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rc_alu_tb.sv
module rc_alu_tb;
  localparam int unsigned WIDTH = 4;
  localparam int unsigned MASK  = (1 << WIDTH) - 1;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WIDTH-1:0] a, reg_y, imm, res;
  logic [1:0] op;
  logic imm_sel, sub, cout;

  int total = 0, bad = 0;
  bit done = 0;

  rc_alu #(.WIDTH(WIDTH)) u_dut (
    .a_i(a), .reg_y_i(reg_y), .imm_i(imm), .imm_sel_i(imm_sel),
    .op_i(op), .sub_i(sub), .res_o(res), .cout_o(cout)
  );

  function automatic logic [WIDTH:0] ref_alu(int av, int yv, int o, bit s);
    int r;
    case (o)
      0: r = s ? (av + ((~yv) & MASK) + 1) : (av + yv);
      1: r = av & yv;
      2: r = av | yv;
      default: r = (~av) & MASK;
    endcase
    return r[WIDTH:0];
  endfunction

  task automatic apply(int av, int rv, int iv, bit isel, int o, bit s, string tag);
    logic [WIDTH:0] exp;
    @(posedge clk);
    a = av[WIDTH-1:0]; reg_y = rv[WIDTH-1:0]; imm = iv[WIDTH-1:0];
    imm_sel = isel; op = o[1:0]; sub = s;
    exp = ref_alu(av & MASK, (isel ? iv : rv) & MASK, o, s);
    @(negedge clk);
    total++;
    if ({cout, res} !== exp) begin
      bad++;
      $display("FAIL %s: a=%0d y=%0d op=%0d sub=%0b isel=%0b got c=%0b r=%0d exp c=%0b r=%0d",
               tag, av, isel ? iv : rv, o, s, isel, cout, res, exp[WIDTH], exp[WIDTH-1:0]);
    end
  endtask

  function automatic string tag_of(int o, bit s);
    case (o)
      0: return s ? "R2" : "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int sd;
    sd = $urandom(32'h1234);
    a = '0; reg_y = '0; imm = '0; imm_sel = 0; op = 0; sub = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    total++;
    // reset state: all-zero inputs add to zero
    if (res !== '0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got c=%0b r=%0d exp c=0 r=0", cout, res);
    end

    // exhaustive sweep; unselected Y source randomized (R6)
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 2; s++)
        for (int isel = 0; isel < 2; isel++)
          for (int av = 0; av <= MASK; av++)
            for (int yv = 0; yv <= MASK; yv++) begin
              int other = $urandom & MASK;
              if (isel) apply(av, other, yv, 1'b1, o, s[0], tag_of(o, s[0]));
              else      apply(av, yv, other, 1'b0, o, s[0], tag_of(o, s[0]));
            end

    // directed corners: full carry ripple
    apply(15, 1, 0, 0, 0, 0, "R1");   // 0 carry 1
    apply(0, 0, 0, 0, 0, 1, "R2");    // carry ripples through all stages
    apply(8, 1, 0, 0, 0, 1, "R2");    // -8-1 wraps
    apply(3, 0, 5, 1, 0, 1, "R6");

    // R5: Y sources irrelevant under NOT
    for (int k = 0; k < 64; k++)
      apply($urandom, $urandom, $urandom, $urandom_range(0,1), 3, $urandom_range(0,1), "R5");

    // R7: sub_i toggled under logic ops, result must match reference with sub ignored
    for (int k = 0; k < 200; k++) begin
      int o = $urandom_range(1, 3);
      apply($urandom, $urandom, $urandom, $urandom_range(0,1), o, $urandom_range(0,1), "R7");
    end

    // R8: signed subtract result in range equals signed difference
    for (int av = -8; av < 8; av++)
      for (int yv = -8; yv < 8; yv++)
        if ((av - yv) >= -8 && (av - yv) <= 7) begin
          logic signed [WIDTH-1:0] sres;
          @(posedge clk);
          a = av[WIDTH-1:0]; reg_y = yv[WIDTH-1:0]; imm = '0;
          imm_sel = 0; op = 2'b00; sub = 1'b1;
          @(negedge clk);
          sres = res;
          total++;
          if (int'(sres) != av - yv) begin
            bad++;
            $display("FAIL R8: a=%0d y=%0d got %0d exp %0d", av, yv, sres, av - yv);
          end
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule